// File: doc/BRIEF.md
# Bytecode Dispatch Table Indexer

This block turns a core's return into a table-driven jump for bytecode interpretation. When the core returns to one of eight reserved targets (0x1F8 through 0x1FF), the unit takes the next byte from a byte-stream source. It keeps a run of high-order bits of that byte as an index and adds the index to a programmable table base. It then reads a 32-bit execute descriptor from a 512-entry lookup RAM. The descriptor is handed to the execution stage together with the raw byte and the stream address it came from. The handler can decode its operand from the unused low-order bits of the raw byte.

The low three bits of the return target set the index width. A target of 0x1F8 uses the whole byte. Each higher target drops one more low-order bit, down to a single-bit index at 0x1FF. The base register is loaded by a set-base command. A handler can issue that command together with its closing return, which lets an interpreter switch between bytecode sets or step through table states. The lookup RAM is loaded through a plain write port. The byte source and the execution stage sit behind valid/ready handshakes.

Top module: `bc_dispatch`

## Requirements
- R1: After reset, `disp_valid` and `byte_ready` are low, the table base is 0, and the unit is idle.
- R2: A return with target 0x1F8..0x1FF, taken while idle, starts a dispatch, and `byte_ready` goes high on the next cycle. Any other target drives `ret_normal` high in the same cycle and starts nothing.
- R3: The shift amount is target[2:0]. The index is byte >> shift, so 0x1F8 uses bits 7:0 and 0x1FF uses bit 7 only.
- R4: The lookup address is (base + index) modulo 512, and `disp_desc` equals the lookup RAM word at that address.
- R5: `setbase_valid` loads `setbase_value` into the base at the clock edge. A load given in the same cycle as the triggering return applies to that dispatch. The base keeps its value across dispatches that carry no load.
- R6: While a dispatch waits for a byte, `byte_ready` stays high and `disp_valid` low until `byte_valid` arrives. Exactly one byte is accepted per dispatch, and a byte offered while idle is not accepted.
- R7: `disp_valid` rises in the cycle after the byte is accepted. `disp_desc`, `disp_byte` and `disp_addr` hold the descriptor, the raw byte and its stream address, and they stay stable until `disp_ready`.
- R8: After the handshake on `disp_valid`/`disp_ready`, the unit returns to idle with both `disp_valid` and `byte_ready` low.
- R9: A write through `lut_we`/`lut_waddr`/`lut_wdata` replaces that table entry for every later dispatch.
- R10: Returns that arrive while a dispatch is in progress are ignored and do not change the index width in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | Core performs a return this cycle |
| ret_target | input | 9 | Return target address |
| ret_normal | output | 1 | Return is an ordinary one (target not reserved) |
| setbase_valid | input | 1 | Load table base |
| setbase_value | input | 9 | New table base |
| lut_we | input | 1 | Lookup RAM write enable |
| lut_waddr | input | 9 | Lookup RAM write address |
| lut_wdata | input | 32 | Lookup RAM write data |
| byte_valid | input | 1 | Byte source has a byte |
| byte_data | input | 8 | Byte from the stream |
| byte_addr | input | 20 | Stream address of that byte |
| byte_ready | output | 1 | Unit accepts the byte this cycle |
| disp_valid | output | 1 | Descriptor is presented |
| disp_desc | output | 32 | Execute descriptor |
| disp_byte | output | 8 | Raw bytecode |
| disp_addr | output | 20 | Stream address of the bytecode |
| disp_ready | input | 1 | Execution stage takes the descriptor |

## Verification
`ret_normal` is combinational and is sampled in the same cycle as the return. `byte_ready` is due one edge after a reserved return, and the descriptor, raw byte and address are due one edge after the accepting edge. They are checked again on every cycle that `disp_ready` is held low. The bench drives inputs on the falling edge and samples them there as well. Each result is therefore read exactly half a period after the rising edge that produced it, and stall and hold lengths vary per case so that the results are seen at more than one distance from their stimulus.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_PRESENT = 2'd2
  } disp_state_e;
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/bcd_trig_decode.sv
module bcd_trig_decode #(
  parameter int          RET_W     = 9,
  parameter int          MODE_W    = 3,
  parameter logic [8:0]  TRIG_BASE = 9'h1F8
) (
  input  logic              ret_valid,
  input  logic [RET_W-1:0]  ret_target,
  output logic              trig_hit,
  output logic              trig_miss,
  output logic [MODE_W-1:0] trig_shift
);
  localparam int HI_W = RET_W - MODE_W;
  localparam logic [RET_W-1:0] BASE_EXT = RET_W'(TRIG_BASE);

  logic region_match;

  always_comb begin
    region_match = (ret_target[RET_W-1:MODE_W] == BASE_EXT[RET_W-1:MODE_W]);
    trig_hit     = ret_valid && region_match;
    trig_miss    = ret_valid && !region_match;
    trig_shift   = ret_target[MODE_W-1:0];
  end

  initial begin
    assert (HI_W > 0) else $error("return target too narrow");
  end
endmodule

// File: rtl/bcd_base_reg.sv
module bcd_base_reg #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n_s,
  input  logic          load,
  input  logic [AW-1:0] load_value,
  output logic [AW-1:0] base_q
);
  logic [AW-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load) base_d = load_value;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) base_q <= '0;
    else          base_q <= base_d;
  end

  assert_base_load_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    load |=> (base_q == $past(load_value)));
  assert_base_hold_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !load |=> $stable(base_q));
endmodule

// File: rtl/bcd_lut_ram.sv
module bcd_lut_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bc_dispatch.sv
module bc_dispatch #(
  parameter int         BYTE_W    = 8,
  parameter int         DESC_W    = 32,
  parameter int         LUT_DEPTH = 512,
  parameter int         SADDR_W   = 20,
  parameter int         RET_W     = 9,
  parameter logic [8:0] TRIG_BASE = 9'h1F8,
  localparam int        LUT_AW    = $clog2(LUT_DEPTH),
  localparam int        MODE_W    = $clog2(BYTE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ret_valid,
  input  logic [RET_W-1:0]   ret_target,
  output logic               ret_normal,
  input  logic               setbase_valid,
  input  logic [LUT_AW-1:0]  setbase_value,
  input  logic               lut_we,
  input  logic [LUT_AW-1:0]  lut_waddr,
  input  logic [DESC_W-1:0]  lut_wdata,
  input  logic               byte_valid,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic [SADDR_W-1:0] byte_addr,
  output logic               byte_ready,
  output logic               disp_valid,
  output logic [DESC_W-1:0]  disp_desc,
  output logic [BYTE_W-1:0]  disp_byte,
  output logic [SADDR_W-1:0] disp_addr,
  input  logic               disp_ready
);
  import bcd_pkg::*;

  logic                rst_n_s;
  logic                trig_hit;
  logic                trig_miss;
  logic [MODE_W-1:0]   trig_shift;
  logic [LUT_AW-1:0]   base_q;
  disp_state_e         state_q, state_d;
  logic [MODE_W-1:0]   shift_q, shift_d;
  logic [BYTE_W-1:0]   byte_q, byte_d;
  logic [SADDR_W-1:0]  addr_q, addr_d;
  logic                start_en;
  logic                accept;
  logic [BYTE_W-1:0]   index;
  logic [LUT_AW-1:0]   lut_raddr;

  bcd_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  bcd_trig_decode #(
    .RET_W     (RET_W),
    .MODE_W    (MODE_W),
    .TRIG_BASE (TRIG_BASE)
  ) u_dec (
    .ret_valid  (ret_valid),
    .ret_target (ret_target),
    .trig_hit   (trig_hit),
    .trig_miss  (trig_miss),
    .trig_shift (trig_shift)
  );

  bcd_base_reg #(.AW(LUT_AW)) u_base (
    .clk        (clk),
    .rst_n_s    (rst_n_s),
    .load       (setbase_valid),
    .load_value (setbase_value),
    .base_q     (base_q)
  );

  // Index field: high-order bits of the byte, width chosen by the mode
  always_comb begin
    index     = byte_data >> shift_q;
    lut_raddr = LUT_AW'(base_q + LUT_AW'(index));
  end

  bcd_lut_ram #(.DEPTH(LUT_DEPTH), .DW(DESC_W)) u_lut (
    .clk   (clk),
    .we    (lut_we),
    .waddr (lut_waddr),
    .wdata (lut_wdata),
    .re    (accept),
    .raddr (lut_raddr),
    .rdata (disp_desc)
  );

  assign ret_normal = trig_miss;
  assign byte_ready = (state_q == ST_FETCH);
  assign disp_valid = (state_q == ST_PRESENT);
  assign accept     = byte_ready && byte_valid;
  assign start_en   = (state_q == ST_IDLE) && trig_hit;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    shift_d = shift_q;
    byte_d  = byte_q;
    addr_d  = addr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_en) begin
          state_d = ST_FETCH;
          shift_d = trig_shift;
        end
      end
      ST_FETCH: begin
        if (accept) begin
          state_d = ST_PRESENT;
          byte_d  = byte_data;
          addr_d  = byte_addr;
        end
      end
      ST_PRESENT: begin
        if (disp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      byte_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_en) shift_q <= shift_d;
      if (accept) begin
        byte_q <= byte_d;
        addr_q <= addr_d;
      end
    end
  end

  assign disp_byte = byte_q;
  assign disp_addr = addr_q;

  assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ret_valid && !ret_normal && !byte_ready && !disp_valid) |=> byte_ready);
  assert_normal_idle_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ret_normal && !byte_ready && !disp_valid) |=> !byte_ready);
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(byte_ready && disp_valid));
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (byte_valid && byte_ready) |=> disp_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (disp_valid && !disp_ready) |=>
      (disp_valid && $stable(disp_desc) && $stable(disp_byte) && $stable(disp_addr)));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (disp_valid && disp_ready) |=> (!disp_valid && !byte_ready));
  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (byte_ready || disp_valid) |=> $stable(shift_q));
endmodule

// File: tb/tb_bc_dispatch.sv
module tb_bc_dispatch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ret_valid;
  logic [8:0]  ret_target;
  logic        ret_normal;
  logic        setbase_valid;
  logic [8:0]  setbase_value;
  logic        lut_we;
  logic [8:0]  lut_waddr;
  logic [31:0] lut_wdata;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic [19:0] byte_addr;
  logic        byte_ready;
  logic        disp_valid;
  logic [31:0] disp_desc;
  logic [7:0]  disp_byte;
  logic [19:0] disp_addr;
  logic        disp_ready;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] lut_model [512];
  logic [8:0]  base_model = 9'h000;

  always #4 clk = ~clk;

  bc_dispatch dut (
    .clk(clk), .rst_n(rst_n),
    .ret_valid(ret_valid), .ret_target(ret_target), .ret_normal(ret_normal),
    .setbase_valid(setbase_valid), .setbase_value(setbase_value),
    .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_addr(byte_addr),
    .byte_ready(byte_ready),
    .disp_valid(disp_valid), .disp_desc(disp_desc), .disp_byte(disp_byte),
    .disp_addr(disp_addr), .disp_ready(disp_ready)
  );

  // {base[8:0], target[8:0], byte[7:0]}
  localparam logic [25:0] VEC [12] = '{
    {9'h000, 9'h1F8, 8'h00}, {9'h000, 9'h1F8, 8'hFF},
    {9'h100, 9'h1F8, 8'h7E}, {9'h040, 9'h1F9, 8'hFF},
    {9'h000, 9'h1FA, 8'hC3}, {9'h010, 9'h1FB, 8'hA7},
    {9'h020, 9'h1FC, 8'h5F}, {9'h003, 9'h1FD, 8'hE0},
    {9'h1FE, 9'h1FE, 8'hC0}, {9'h000, 9'h1FF, 8'h80},
    {9'h1FF, 9'h1FF, 8'h7F}, {9'h1F0, 9'h1F8, 8'hFF}
  };

  function automatic logic [31:0] fill_word(int i);
    logic [8:0] a = 9'(i);
    return {a ^ 9'h155, 7'h3A, ~a[7:0], a[7:0]};
  endfunction

  function automatic logic [8:0] exp_index(logic [8:0] b, logic [8:0] t, logic [7:0] d);
    logic [7:0] idx = d >> t[2:0];
    return 9'(b + {1'b0, idx});
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lut_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    lut_we = 1'b1; lut_waddr = a; lut_wdata = d;
    lut_model[a] = d;
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  task automatic dispatch(input bit load, input logic [8:0] b, input logic [8:0] t,
                          input logic [7:0] d, input logic [19:0] a,
                          input int stall, input int hold, input string req);
    logic [31:0] exp_desc;
    @(negedge clk);
    ret_valid = 1'b1; ret_target = t;
    setbase_valid = load; setbase_value = b;
    if (load) base_model = b;
    @(negedge clk);
    ret_valid = 1'b0; setbase_valid = 1'b0;
    chk(byte_ready === 1'b1, "R2", 32'(byte_ready), 32'd1);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(byte_ready === 1'b1 && disp_valid === 1'b0, "R6",
          {byte_ready, disp_valid}, 32'b10);
    end
    byte_valid = 1'b1; byte_data = d; byte_addr = a;
    @(negedge clk);
    byte_valid = 1'b0; byte_data = 8'h00;
    exp_desc = lut_model[exp_index(base_model, t, d)];
    chk(disp_valid === 1'b1 && byte_ready === 1'b0, "R7", {disp_valid, byte_ready}, 32'b10);
    chk(disp_desc === exp_desc, {req, " R3 R4"}, disp_desc, exp_desc);
    chk(disp_byte === d && disp_addr === a, "R7", {disp_byte, 4'h0, disp_addr}, {d, 4'h0, a});
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(disp_valid === 1'b1 && disp_desc === exp_desc && disp_byte === d, "R7",
          disp_desc, exp_desc);
    end
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;
    chk(disp_valid === 1'b0 && byte_ready === 1'b0, "R8", {disp_valid, byte_ready}, 32'b00);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ret_valid = 0; ret_target = '0; setbase_valid = 0; setbase_value = '0;
    lut_we = 0; lut_waddr = '0; lut_wdata = '0;
    byte_valid = 0; byte_data = '0; byte_addr = '0; disp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(disp_valid === 1'b0 && byte_ready === 1'b0, "R1", {disp_valid, byte_ready}, 32'b00);

    // R9: fill the table through the write port
    for (int i = 0; i < 512; i++) lut_write(9'(i), fill_word(i));

    // R1: base is 0 after reset, so no load gives entry 0x05
    dispatch(1'b0, 9'h000, 9'h1F8, 8'h05, 20'h00AAA, 0, 0, "R1");

    // Vector table: R3/R4/R5, stall and hold lengths varied
    for (int v = 0; v < 12; v++)
      dispatch(1'b1, VEC[v][25:17], VEC[v][16:8], VEC[v][7:0],
               20'h01000 + 20'(v * 3), v % 3, v % 2, "R5");

    // R5: base persists when no load accompanies the return
    dispatch(1'b0, 9'h000, 9'h1FC, 8'h30, 20'h02000, 1, 0, "R5");

    // R2: non-reserved returns
    @(negedge clk);
    ret_valid = 1'b1; ret_target = 9'h1F7;
    #1 chk(ret_normal === 1'b1, "R2", 32'(ret_normal), 32'd1);
    @(negedge clk);
    ret_target = 9'h000;
    chk(byte_ready === 1'b0, "R2", 32'(byte_ready), 32'd0);
    #1 chk(ret_normal === 1'b1, "R2", 32'(ret_normal), 32'd1);
    @(negedge clk);
    ret_valid = 1'b0;
    chk(byte_ready === 1'b0, "R2", 32'(byte_ready), 32'd0);

    // R6: a byte offered while idle is not taken
    byte_valid = 1'b1; byte_data = 8'hEE;
    @(negedge clk);
    chk(byte_ready === 1'b0 && disp_valid === 1'b0, "R6", {byte_ready, disp_valid}, 32'b00);
    byte_valid = 1'b0;

    // R10: a second return during the fetch wait does not change the mode
    @(negedge clk);
    ret_valid = 1'b1; ret_target = 9'h1F8; setbase_valid = 1'b1; setbase_value = 9'h000;
    base_model = 9'h000;
    @(negedge clk);
    ret_target = 9'h1FF;
    @(negedge clk);
    ret_valid = 1'b0; setbase_valid = 1'b0;
    byte_valid = 1'b1; byte_data = 8'h40; byte_addr = 20'h03000;
    @(negedge clk);
    byte_valid = 1'b0;
    chk(disp_desc === lut_model[9'h040], "R10", disp_desc, lut_model[9'h040]);
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;

    // R9: overwrite one entry and dispatch to it
    lut_write(9'h0AB, 32'hDEADBEEF);
    dispatch(1'b1, 9'h0AB, 9'h1F8, 8'h00, 20'h04000, 0, 1, "R9");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule